// File: doc/BRIEF.md
# Audio Subframe Bit Serializer

This block turns buffered audio samples into the raw bit stream of a 32-slot audio subframe. A slot counter advances once per bit-clock enable. On the enable that closes slot 31, a 27-bit shift register is loaded for the coming subframe. Its low 24 bits hold the sample for that channel and its top three bits hold the validity, user and channel-status flags. During slots 4 to 30 the register shifts toward bit 0, one position per enable, so the sample leaves LSB first and the three flags follow it. Slots 0 to 3 carry 0, which leaves room for a preamble. Slot 31 carries 0, which leaves room for parity. The slot index is exported, so a later stage can add the preamble, parity and line coding.

Subframes alternate between channel A and channel B, starting with A after reset. The channel A flags are taken straight from the flag inputs when the A subframe loads. At that same moment a private copy of the channel B flags is taken. The following B subframe sends that copy, so flag changes made by the host during the A subframe do not alter the frame in progress. In slot 31 a one-cycle request strobe, together with a channel indicator, tells the sample buffer which sample must be present at the next enable. The shift register has no host read or write path.

Top module: `subframe_serializer`

## Requirements
- R1: While `rst` is high at a clock edge, the block resets as follows: `slot_idx` becomes 31, `chan_b` becomes 1, `ser_bit` becomes 0 and `nxt_req` becomes 0. As a result, the first enable after reset starts a channel A subframe at slot 0.
- R2: Each clock edge with `bit_en` high advances `slot_idx` by one. From 31 it wraps to 0.
- R3: `chan_b` toggles at every wrap from slot 31 to slot 0. It is 0 during a channel A subframe and 1 during a channel B subframe.
- R4: `ser_bit` is 0 in slots 0, 1, 2, 3 and 31.
- R5: In slot 4+k (k = 0..23), `ser_bit` equals bit k of the sample that was on `smp_a` (channel A) or `smp_b` (channel B) at the enable that started the subframe.
- R6: Flag inputs are encoded as bit 0 = validity, bit 1 = user, bit 2 = channel status. These go out at slot 28, slot 29 and slot 30 respectively. A channel A subframe sends `na_a` as sampled at its starting enable.
- R7: A channel B subframe sends the value that `na_b` had at the start of the preceding channel A subframe. Any later change to `na_b` has no effect on it.
- R8: `nxt_req` is high for exactly one clock after the enable that enters slot 31. While it is high, `nxt_b` is 1 if a channel B sample is wanted next and 0 if a channel A sample is wanted next.
- R9: A clock edge with `bit_en` low leaves `slot_idx`, `chan_b` and `ser_bit` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-slot enable, one per slot |
| smp_a | input | 24 | Channel A sample from the buffer |
| smp_b | input | 24 | Channel B sample from the buffer |
| na_a | input | 3 | Channel A flags: [0] validity, [1] user, [2] status |
| na_b | input | 3 | Channel B flags, same encoding |
| ser_bit | output | 1 | Serial bit for the current slot |
| slot_idx | output | 5 | Current slot index, 0 to 31 |
| chan_b | output | 1 | 1 while a channel B subframe is running |
| nxt_req | output | 1 | One-clock request for the next sample |
| nxt_b | output | 1 | Channel wanted by the request (1 = B) |

## Verification
Every result lags its enable by exactly one register stage. After a clock edge with `bit_en` high, the new slot, channel and serial bit are all valid. The request strobe is valid after the edge that enters slot 31. A freshly presented sample shows up at slot 4 of the subframe whose starting edge captured it. The bench drives inputs on the falling edge and reads every output on the next falling edge, which is half a period after the rising edge that updated them. Its model copies the sample and flag inputs at the very edge that wraps slot 31. It scrambles the inputs after that edge and during idle cycles, so any late sampling of the inputs shows up as a mismatch.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;
endpackage

// File: rtl/sfs_slot_timer.sv
module sfs_slot_timer #(
  parameter int SLOTS  = 32,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  output logic [SLOT_W-1:0] slot_o,
  output sfs_pkg::chan_e    chan_o,
  output logic              wrap_o,
  output logic              req_o,
  output logic              req_b_o
);
  import sfs_pkg::*;

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] PRE_LAST  = SLOT_W'(SLOTS - 2);

  logic [SLOT_W-1:0] slot_q;
  chan_e             chan_q;
  logic              req_q, req_b_q;

  assign wrap_o  = bit_en && (slot_q == LAST_SLOT);
  assign slot_o  = slot_q;
  assign chan_o  = chan_q;
  assign req_o   = req_q;
  assign req_b_o = req_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= LAST_SLOT;
      chan_q  <= CH_B;
      req_q   <= 1'b0;
      req_b_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (bit_en) begin
        if (slot_q == LAST_SLOT) begin
          slot_q <= '0;
          chan_q <= (chan_q == CH_A) ? CH_B : CH_A;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
        if (slot_q == PRE_LAST) begin
          req_q   <= 1'b1;
          req_b_q <= (chan_q == CH_A);
        end
      end
    end
  end

  // R2: wrap from last slot to zero
  a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
    (bit_en && slot_q == LAST_SLOT) |=> (slot_q == '0));

  // R3: channel flips on every wrap
  a_r3_chan_toggle: assert property (@(posedge clk) disable iff (rst)
    (bit_en && slot_q == LAST_SLOT) |=> (chan_q != $past(chan_q)));

  // R9: idle cycles hold the counter and channel
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(slot_q) && $stable(chan_q)));

  // R8: request is a single-cycle pulse
  a_r8_one_shot: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter #(
  parameter int SMP_W       = 24,
  parameter int NA_W        = 3,
  parameter int SLOTS       = 32,
  parameter int SLOT_W      = 5,
  parameter int FIRST_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              load,
  input  logic              load_b,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SMP_W-1:0]  smp_a,
  input  logic [SMP_W-1:0]  smp_b,
  input  logic [NA_W-1:0]   na_a,
  input  logic [NA_W-1:0]   na_b,
  output logic              ser_bit
);
  localparam int SR_W       = SMP_W + NA_W;
  localparam int LAST_SHIFT = FIRST_SHIFT + SR_W - 1;
  localparam logic [SLOT_W-1:0] WIN_LO    = SLOT_W'(FIRST_SHIFT);
  localparam logic [SLOT_W-1:0] WIN_HI    = SLOT_W'(LAST_SHIFT);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SR_W-1:0] sr_q;
  logic [NA_W-1:0] hold_b_q;
  logic            in_win;

  assign in_win  = (slot >= WIN_LO) && (slot <= WIN_HI);
  assign ser_bit = in_win & sr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      hold_b_q <= '0;
    end else if (bit_en) begin
      if (load) begin
        if (load_b) begin
          sr_q <= {hold_b_q, smp_b};
        end else begin
          sr_q     <= {na_a, smp_a};
          hold_b_q <= na_b;
        end
      end else if (in_win) begin
        sr_q <= {1'b0, sr_q[SR_W-1:1]};
      end
    end
  end

  // R7: the channel B flag copy changes only when channel A loads
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !(bit_en && load && !load_b) |=> $stable(hold_b_q));

  // R5: every loaded bit has left the register by the parity slot
  a_r5_drained_at_parity: assert property (@(posedge clk) disable iff (rst)
    (slot == LAST_SLOT) |-> (sr_q == '0));
endmodule

// File: rtl/subframe_serializer.sv
module subframe_serializer #(
  parameter int SMP_W       = 24,
  parameter int NA_W        = 3,
  parameter int SLOTS       = 32,
  parameter int FIRST_SHIFT = 4,
  localparam int SLOT_W     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [SMP_W-1:0]  smp_a,
  input  logic [SMP_W-1:0]  smp_b,
  input  logic [NA_W-1:0]   na_a,
  input  logic [NA_W-1:0]   na_b,
  output logic              ser_bit,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              chan_b,
  output logic              nxt_req,
  output logic              nxt_b
);
  import sfs_pkg::*;

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  chan_e chan;
  logic  wrap;

  sfs_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .slot_o (slot_idx),
    .chan_o (chan),
    .wrap_o (wrap),
    .req_o  (nxt_req),
    .req_b_o(nxt_b)
  );

  sfs_shifter #(
    .SMP_W(SMP_W), .NA_W(NA_W), .SLOTS(SLOTS),
    .SLOT_W(SLOT_W), .FIRST_SHIFT(FIRST_SHIFT)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .load   (wrap),
    .load_b (chan == CH_A),
    .slot   (slot_idx),
    .smp_a  (smp_a),
    .smp_b  (smp_b),
    .na_a   (na_a),
    .na_b   (na_b),
    .ser_bit(ser_bit)
  );

  assign chan_b = (chan == CH_B);

  // R8: request is only seen in the last slot
  a_r8_req_in_last: assert property (@(posedge clk) disable iff (rst)
    nxt_req |-> (slot_idx == LAST_SLOT));

  // R4: preamble slots carry zero
  a_r4_preamble_zero: assert property (@(posedge clk) disable iff (rst)
    (slot_idx < SLOT_W'(FIRST_SHIFT)) |-> !ser_bit);
endmodule

// File: tb/tb_subframe_serializer.sv
module tb_subframe_serializer;
  logic        clk = 1'b0;
  logic        rst, bit_en;
  logic [23:0] smp_a, smp_b;
  logic [2:0]  na_a, na_b;
  logic        ser_bit, chan_b, nxt_req, nxt_b;
  logic [4:0]  slot_idx;

  int checks = 0;
  int fails  = 0;

  int          eslot;
  logic        echan_b;
  logic [26:0] eword;
  logic [2:0]  ehold;

  always #2 clk = ~clk;

  subframe_serializer dut (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .smp_a(smp_a), .smp_b(smp_b), .na_a(na_a), .na_b(na_b),
    .ser_bit(ser_bit), .slot_idx(slot_idx), .chan_b(chan_b),
    .nxt_req(nxt_req), .nxt_b(nxt_b)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (slot %0d)", req, act, exp, eslot);
    end
  endtask

  function automatic logic exp_bit(input int s, input logic [26:0] w);
    if (s >= 4 && s <= 30) return w[s-4];
    return 1'b0;
  endfunction

  task automatic scramble();
    smp_a = 24'($urandom);
    smp_b = 24'($urandom);
    na_a  = 3'($urandom);
    na_b  = 3'($urandom);
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic clk_step(input logic en);
    bit_en = en;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic check_all();
    string sreq;
    chk(slot_idx == 5'(eslot), "R2 slot", 32'(slot_idx), 32'(eslot));
    chk(chan_b == echan_b, "R3 chan", 32'(chan_b), 32'(echan_b));
    if (eslot < 4 || eslot == 31) sreq = "R4 zero slot";
    else if (eslot < 28) sreq = "R5 audio bit";
    else if (echan_b) sreq = "R7 held B flag";
    else sreq = "R6 flag bit";
    chk(ser_bit == exp_bit(eslot, eword), sreq, 32'(ser_bit),
        32'(exp_bit(eslot, eword)));
    chk(nxt_req == (eslot == 31), "R8 req", 32'(nxt_req), 32'(eslot == 31));
    if (eslot == 31)
      chk(nxt_b == !echan_b, "R8 next chan", 32'(nxt_b), 32'(!echan_b));
  endtask

  task automatic advance();
    logic [23:0] sa, sb;
    logic [2:0]  fa, fb;
    sa = smp_a; sb = smp_b; fa = na_a; fb = na_b;
    clk_step(1'b1);
    if (eslot == 31) begin
      eslot   = 0;
      echan_b = !echan_b;
      if (!echan_b) begin
        eword = {fa, sa};
        ehold = fb;
      end else begin
        eword = {ehold, sb};
      end
    end else begin
      eslot++;
    end
    check_all();
  endtask

  task automatic idle_check();
    logic [4:0] s0;
    logic       c0, b0;
    s0 = slot_idx; c0 = chan_b; b0 = ser_bit;
    scramble();
    clk_step(1'b0);
    chk(slot_idx == s0 && chan_b == c0 && ser_bit == b0, "R9 idle hold",
        {slot_idx, chan_b, ser_bit}, {s0, c0, b0});
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; bit_en = 1'b1;
    scramble();
    repeat (3) @(negedge clk);
    rst = 1'b0; bit_en = 1'b0;
    eslot = 31; echan_b = 1'b1; eword = '0; ehold = '0;
    chk(slot_idx == 5'd31, "R1 reset slot", 32'(slot_idx), 32'd31);
    chk(chan_b == 1'b1, "R1 reset chan", 32'(chan_b), 32'd1);
    chk(ser_bit == 1'b0, "R1 reset bit", 32'(ser_bit), 32'd0);
    chk(nxt_req == 1'b0, "R1 reset req", 32'(nxt_req), 32'd0);

    for (int sf = 0; sf < 60; sf++) begin
      // inputs for the load edge: directed corners then random
      case (sf % 8)
        0: begin smp_a = '1; smp_b = '1; na_a = 3'b111; na_b = 3'b111; end
        1: begin smp_a = '0; smp_b = '0; na_a = 3'b000; na_b = 3'b000; end
        2: begin smp_a = 24'h555555; smp_b = 24'hAAAAAA; na_a = 3'b001; na_b = 3'b100; end
        3: begin smp_a = 24'h800001; smp_b = 24'h800001; na_a = 3'b010; na_b = 3'b010; end
        default: scramble();
      endcase
      advance();
      for (int s = 1; s < 32; s++) begin
        scramble();
        if ($urandom_range(0, 5) == 0) idle_check();
        advance();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule